// File: doc/BRIEF.md
# Direct-Mapped Tag Cache with Victim Buffer

This block keeps the tag state of a small direct-mapped cache and of a fully associative victim buffer placed behind it. A reference address is presented on one cycle. On the next cycle the block reports whether the line was found and updates its line state. The data array, the memory side and the write policy are not part of the block. A miss installs the requested line at once, in the same update.

When a conflict pushes a valid line out of its set, the line moves into the victim buffer. The buffer chooses a free entry first and otherwise takes its least-recently-used entry. A later reference that finds its line in the buffer counts as a hit. That line and the present occupant of its set then trade places. Every line's valid bit and line address are visible on outputs, and so is the index of the least-recently-used victim entry. A checker can therefore follow the whole state after each reference.

Top module: `victim_dm_cache`

## Requirements
- R1: While reset is asserted and on the first cycle after it, all main lines and victim entries read invalid, `respValid` is 0 and `victimLru` equals VICTIMS-1 (1 with defaults).
- R2: The line address is `refAddr[15:4]` and the set is `refAddr[5:4]`. The byte offset `refAddr[3:0]` has no effect, so 0x47 hits a line filled by 0x40.
- R3: A reference whose line is found in neither structure returns `respHit`=0 and `respFromVictim`=0, and leaves that line valid in its set.
- R4: A reference that matches its main set returns `respHit`=1 and `respFromVictim`=0, and leaves all line state and `victimLru` unchanged.
- R5: On a miss where the set held a valid line, that old line is written into the lowest-numbered invalid victim entry, or into the entry named by `victimLru` when every entry is valid.
- R6: A reference that matches victim entry k returns `respHit`=1 and `respFromVictim`=1. The set then holds the requested line and entry k holds the line that the set held before.
- R7: The victim entry written on a miss or a swap becomes most recently used, and `victimLru` names the entry touched least recently.
- R8: The response to a reference sampled at a clock edge appears on the outputs after that edge. A cycle with `refValid`=0 produces `respValid`=0 and changes no state.
- R9: A miss into a set whose line is invalid leaves every victim entry and `victimLru` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| refValid | input | 1 | A reference is presented this cycle |
| refAddr | input | ADDR_W (16) | Byte address of the reference |
| respValid | output | 1 | Result of the previous cycle's reference |
| respHit | output | 1 | Line was found in the main set or victim buffer |
| respFromVictim | output | 1 | Line was found in the victim buffer |
| mainValid | output | SETS (4) | Valid bit per main set |
| mainLine | output | SETS*LINE_W (48) | Line address per set, set s at bits [s*12 +: 12] |
| victimValid | output | VICTIMS (2) | Valid bit per victim entry |
| victimLine | output | VICTIMS*LINE_W (24) | Line address per victim entry, entry k at bits [k*12 +: 12] |
| victimLru | output | VIC_W (1) | Index of the least-recently-used victim entry |

## Verification
The hardest state to reach is a full victim buffer whose recency order has just been changed by a swap. In that state the next conflicting miss must evict the entry that was not swapped. The directed trace gets there by sending three and then four distinct lines through set 0. It then recalls the older victim, so a swap reorders the buffer, and then brings in a fresh conflicting line. After that, a long pseudo-random run over 32 lines spread across the four sets mixes swaps, evictions and main hits. A bench model predicts every step of it.

// File: rtl/vcache_pkg.sv
package vcache_pkg;
  typedef struct packed {
    logic respond;
    logic hit;
    logic fromVictim;
    logic fillMain;
    logic pushVictim;
  } ctrlStrobes_t;
endpackage

// File: rtl/vcache_datapath.sv
module vcache_datapath
  import vcache_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int OFFSET_W = 4,
  parameter int SETS     = 4,
  parameter int VICTIMS  = 2,
  localparam int INDEX_W = $clog2(SETS),
  localparam int LINE_W  = ADDR_W - OFFSET_W,
  localparam int TAG_W   = LINE_W - INDEX_W,
  localparam int VIC_W   = $clog2(VICTIMS)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [ADDR_W-1:0]         refAddr,
  input  ctrlStrobes_t              strobes,
  input  logic [VIC_W-1:0]          slotSel,
  output logic                      mainHit,
  output logic [VICTIMS-1:0]        victimMatch,
  output logic                      setValid,
  output logic [VICTIMS-1:0]        victimValid,
  output logic [VIC_W-1:0]          lruIdx,
  output logic [SETS-1:0]           mainValid,
  output logic [SETS*LINE_W-1:0]    mainLine,
  output logic [VICTIMS*LINE_W-1:0] victimLine
);
  logic [SETS-1:0]    mainValidQ;
  logic [TAG_W-1:0]   mainTagQ [SETS];
  logic [VICTIMS-1:0] vicValidQ;
  logic [LINE_W-1:0]  vicLineQ [VICTIMS];
  logic [VIC_W-1:0]   rankQ    [VICTIMS];

  logic [LINE_W-1:0]  refLine;
  logic [INDEX_W-1:0] refIdx;
  logic [TAG_W-1:0]   refTag;
  logic [LINE_W-1:0]  oldLine;

  assign refLine = refAddr[ADDR_W-1:OFFSET_W];
  assign refIdx  = refLine[INDEX_W-1:0];
  assign refTag  = refLine[LINE_W-1:INDEX_W];
  assign setValid = mainValidQ[refIdx];
  assign mainHit  = mainValidQ[refIdx] && (mainTagQ[refIdx] == refTag);
  assign oldLine  = {mainTagQ[refIdx], refIdx};
  assign victimValid = vicValidQ;
  assign mainValid   = mainValidQ;

  for (genvar s = 0; s < SETS; s++) begin : g_main
    assign mainLine[s*LINE_W +: LINE_W] = {mainTagQ[s], INDEX_W'(s)};
  end

  for (genvar k = 0; k < VICTIMS; k++) begin : g_vic
    assign victimMatch[k] = vicValidQ[k] && (vicLineQ[k] == refLine);
    assign victimLine[k*LINE_W +: LINE_W] = vicLineQ[k];
  end

  always_comb begin
    lruIdx = '0;
    for (int k = 0; k < VICTIMS; k++)
      if (rankQ[k] == VIC_W'(VICTIMS-1)) lruIdx = VIC_W'(k);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mainValidQ <= '0;
      vicValidQ  <= '0;
      for (int s = 0; s < SETS; s++) mainTagQ[s] <= '0;
      for (int k = 0; k < VICTIMS; k++) begin
        vicLineQ[k] <= '0;
        rankQ[k]    <= VIC_W'(k);
      end
    end else begin
      if (strobes.fillMain) begin
        mainValidQ[refIdx] <= 1'b1;
        mainTagQ[refIdx]   <= refTag;
      end
      if (strobes.pushVictim) begin
        vicValidQ[slotSel] <= mainValidQ[refIdx];
        vicLineQ[slotSel]  <= oldLine;
        for (int k = 0; k < VICTIMS; k++) begin
          if (VIC_W'(k) == slotSel) rankQ[k] <= '0;
          else if (rankQ[k] < rankQ[slotSel]) rankQ[k] <= rankQ[k] + 1'b1;
        end
      end
    end
  end

  // R6
  victim_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(victimMatch));

  // R4
  exclusive_hit_chk: assert property (@(posedge clk) disable iff (rst)
    !(mainHit && (|victimMatch)));

  // R3
  fill_lands_chk: assert property (@(posedge clk) disable iff (rst)
    strobes.fillMain |=> mainValidQ[$past(refIdx)] && (mainTagQ[$past(refIdx)] == $past(refTag)));

  // R7
  touch_mru_chk: assert property (@(posedge clk) disable iff (rst)
    strobes.pushVictim |=> lruIdx != $past(slotSel));
endmodule

// File: rtl/vcache_ctrl.sv
module vcache_ctrl
  import vcache_pkg::*;
#(
  parameter int VICTIMS = 2,
  localparam int VIC_W  = $clog2(VICTIMS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               refValid,
  input  logic               mainHit,
  input  logic [VICTIMS-1:0] victimMatch,
  input  logic               setValid,
  input  logic [VICTIMS-1:0] victimValid,
  input  logic [VIC_W-1:0]   lruIdx,
  output ctrlStrobes_t       strobes,
  output logic [VIC_W-1:0]   slotSel,
  output logic               respValid,
  output logic               respHit,
  output logic               respFromVictim
);
  logic             anyVic;
  logic [VIC_W-1:0] hitIdx;
  logic             freeFound;
  logic [VIC_W-1:0] freeIdx;

  assign anyVic = |victimMatch;

  always_comb begin
    hitIdx    = '0;
    freeFound = 1'b0;
    freeIdx   = '0;
    for (int k = 0; k < VICTIMS; k++)
      if (victimMatch[k]) hitIdx = VIC_W'(k);
    for (int k = VICTIMS-1; k >= 0; k--)
      if (!victimValid[k]) begin
        freeFound = 1'b1;
        freeIdx   = VIC_W'(k);
      end
  end

  always_comb begin
    strobes            = '0;
    strobes.respond    = refValid;
    strobes.hit        = refValid && (mainHit || anyVic);
    strobes.fromVictim = refValid && anyVic;
    strobes.fillMain   = refValid && !mainHit;
    strobes.pushVictim = refValid && !mainHit && (anyVic || setValid);
    if (anyVic)         slotSel = hitIdx;
    else if (freeFound) slotSel = freeIdx;
    else                slotSel = lruIdx;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      respValid      <= 1'b0;
      respHit        <= 1'b0;
      respFromVictim <= 1'b0;
    end else begin
      respValid      <= strobes.respond;
      respHit        <= strobes.hit;
      respFromVictim <= strobes.fromVictim;
    end
  end

  // R8
  resp_follows_chk: assert property (@(posedge clk) disable iff (rst)
    refValid |=> respValid);

  // R8
  no_spurious_resp_chk: assert property (@(posedge clk) disable iff (rst)
    !refValid |=> !respValid);

  // R5
  evict_target_chk: assert property (@(posedge clk) disable iff (rst)
    (strobes.pushVictim && !anyVic) |-> (!victimValid[slotSel] || (slotSel == lruIdx)));
endmodule

// File: rtl/victim_dm_cache.sv
module victim_dm_cache
  import vcache_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int OFFSET_W = 4,
  parameter int SETS     = 4,
  parameter int VICTIMS  = 2,
  localparam int LINE_W  = ADDR_W - OFFSET_W,
  localparam int VIC_W   = $clog2(VICTIMS)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      refValid,
  input  logic [ADDR_W-1:0]         refAddr,
  output logic                      respValid,
  output logic                      respHit,
  output logic                      respFromVictim,
  output logic [SETS-1:0]           mainValid,
  output logic [SETS*LINE_W-1:0]    mainLine,
  output logic [VICTIMS-1:0]        victimValid,
  output logic [VICTIMS*LINE_W-1:0] victimLine,
  output logic [VIC_W-1:0]          victimLru
);
  ctrlStrobes_t       strobes;
  logic [VIC_W-1:0]   slotSel;
  logic               mainHit;
  logic [VICTIMS-1:0] victimMatch;
  logic               setValid;

  vcache_datapath #(
    .ADDR_W(ADDR_W), .OFFSET_W(OFFSET_W), .SETS(SETS), .VICTIMS(VICTIMS)
  ) u_dp (
    .clk(clk), .rst(rst), .refAddr(refAddr), .strobes(strobes), .slotSel(slotSel),
    .mainHit(mainHit), .victimMatch(victimMatch), .setValid(setValid),
    .victimValid(victimValid), .lruIdx(victimLru), .mainValid(mainValid),
    .mainLine(mainLine), .victimLine(victimLine)
  );

  vcache_ctrl #(.VICTIMS(VICTIMS)) u_ctrl (
    .clk(clk), .rst(rst), .refValid(refValid), .mainHit(mainHit),
    .victimMatch(victimMatch), .setValid(setValid), .victimValid(victimValid),
    .lruIdx(victimLru), .strobes(strobes), .slotSel(slotSel),
    .respValid(respValid), .respHit(respHit), .respFromVictim(respFromVictim)
  );
endmodule

// File: tb/victim_dm_cache_tb.sv
`timescale 1ns/1ps
module victim_dm_cache_tb;
  localparam int SETS = 4;
  localparam int VICTIMS = 2;
  localparam int LW = 12;

  typedef struct {
    int          kind;   // 0 miss clean, 1 miss evict, 2 main hit, 3 victim hit
    logic        hit;
    logic        fromV;
    logic [3:0]  mV;
    logic [47:0] mL;
    logic [1:0]  vV;
    logic [23:0] vL;
    logic        lru;
  } expItem_t;

  logic clk = 0;
  logic rst = 1;
  logic refValid = 0;
  logic [15:0] refAddr = '0;
  logic respValid, respHit, respFromVictim;
  logic [3:0]  mainValid;
  logic [47:0] mainLine;
  logic [1:0]  victimValid;
  logic [23:0] victimLine;
  logic        victimLru;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [3:0]  mV;
  logic [11:0] mL [4];
  logic [1:0]  vV;
  logic [11:0] vL [2];
  logic        lru;
  expItem_t    q[$];

  always #2.5 clk = ~clk;

  victim_dm_cache u_dut (
    .clk(clk), .rst(rst), .refValid(refValid), .refAddr(refAddr),
    .respValid(respValid), .respHit(respHit), .respFromVictim(respFromVictim),
    .mainValid(mainValid), .mainLine(mainLine), .victimValid(victimValid),
    .victimLine(victimLine), .victimLru(victimLru)
  );

  function automatic logic [47:0] packMain();
    logic [47:0] r = '0;
    for (int s = 0; s < 4; s++) r[s*12 +: 12] = mV[s] ? mL[s] : {10'h0, 2'(s)};
    return r;
  endfunction

  function automatic logic [23:0] packVic();
    return {vL[1], vL[0]};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // compare main lines only where valid (invalid line address is don't-care)
  task automatic checkState(input string req, input expItem_t e);
    logic [47:0] actM;
    actM = mainLine;
    for (int s = 0; s < 4; s++) if (!e.mV[s]) actM[s*12 +: 12] = {10'h0, 2'(s)};
    check(req, {60'h0, mainValid}, {60'h0, e.mV});
    check(req, {16'h0, actM}, {16'h0, e.mL});
    check(req, {62'h0, victimValid}, {62'h0, e.vV});
    for (int k = 0; k < 2; k++)
      if (e.vV[k]) check(req, {52'h0, victimLine[k*12 +: 12]}, {52'h0, e.vL[k*12 +: 12]});
  endtask

  task automatic modelRef(input logic [15:0] a, output expItem_t e);
    logic [11:0] line;
    logic [1:0]  idx;
    int k;
    int slot;
    line = a[15:4];
    idx  = line[1:0];
    k    = -1;
    for (int j = 0; j < 2; j++) if (vV[j] && vL[j] == line) k = j;
    if (mV[idx] && mL[idx] == line) begin
      e.kind = 2; e.hit = 1; e.fromV = 0;
    end else if (k >= 0) begin
      e.kind = 3; e.hit = 1; e.fromV = 1;
      vV[k] = mV[idx]; vL[k] = mL[idx];
      mV[idx] = 1; mL[idx] = line;
      lru = (k == 0);
    end else begin
      e.hit = 0; e.fromV = 0;
      if (mV[idx]) begin
        e.kind = 1;
        slot = !vV[0] ? 0 : (!vV[1] ? 1 : int'(lru));
        vV[slot] = 1; vL[slot] = mL[idx];
        lru = (slot == 0);
      end else e.kind = 0;
      mV[idx] = 1; mL[idx] = line;
    end
    e.mV = mV; e.mL = packMain(); e.vV = vV; e.vL = packVic(); e.lru = lru;
  endtask

  task automatic doRef(input logic [15:0] a);
    expItem_t e;
    @(negedge clk);
    refValid = 1;
    refAddr  = a;
    modelRef(a, e);
    q.push_back(e);
  endtask

  task automatic idle();
    @(negedge clk);
    refValid = 0;
  endtask

  // monitor: pops expected item for each response
  always @(negedge clk) begin
    if (!rst && respValid) begin
      if (q.size() == 0) begin
        check("R8 unexpected response", 64'h1, 64'h0);
      end else begin
        expItem_t e;
        e = q.pop_front();
        case (e.kind)
          0: begin
            check("R3 hit flag", {63'h0, respHit}, 64'h0);
            checkState("R9 clean miss state", e);
          end
          1: begin
            check("R3 hit flag", {63'h0, respHit}, 64'h0);
            checkState("R5 evicting miss state", e);
          end
          2: begin
            check("R4 hit flag", {63'h0, respHit}, 64'h1);
            check("R4 victim flag", {63'h0, respFromVictim}, 64'h0);
            checkState("R4 main hit state", e);
          end
          default: begin
            check("R6 hit flag", {63'h0, respHit}, 64'h1);
            check("R6 victim flag", {63'h0, respFromVictim}, 64'h1);
            checkState("R6 swap state", e);
          end
        endcase
        check("R7 lru pointer", {63'h0, victimLru}, {63'h0, e.lru});
      end
    end
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    expItem_t dummy;
    mV = '0; vV = '0; lru = 1;
    for (int s = 0; s < 4; s++) mL[s] = '0;
    vL[0] = '0; vL[1] = '0;
    repeat (3) @(negedge clk);
    // R1 reset state while held and after release
    check("R1 main valid in reset", {60'h0, mainValid}, 64'h0);
    check("R1 victim valid in reset", {62'h0, victimValid}, 64'h0);
    check("R1 lru in reset", {63'h0, victimLru}, 64'h1);
    rst = 0;
    @(negedge clk);
    check("R1 resp after reset", {63'h0, respValid}, 64'h0);
    check("R1 main valid after reset", {60'h0, mainValid}, 64'h0);

    // directed: conflicts in set 0, offset alias, victim full, swap reorders LRU
    doRef(16'h0000);  // clean miss R9
    doRef(16'h0040);  // evict 0x000 -> v0 R5
    doRef(16'h0047);  // R2 offset ignored: main hit
    doRef(16'h0080);  // evict 0x004 -> v1
    doRef(16'h0000);  // victim hit on v0, swap R6
    doRef(16'h00C0);  // victim full: evict LRU (v1)
    doRef(16'h0048);  // line 0x004 now gone -> miss
    doRef(16'h0010);  // set 1 clean
    doRef(16'h0050);
    doRef(16'h0013);  // victim hit set 1
    idle();
    idle();
    // R8: idle leaves state alone
    dummy.mV = mV; dummy.mL = packMain(); dummy.vV = vV; dummy.vL = packVic();
    check("R8 no resp when idle", {63'h0, respValid}, 64'h0);
    checkState("R8 idle state", dummy);
    check("R8 idle lru", {63'h0, victimLru}, {63'h0, lru});

    lfsr = 16'hACE1;
    for (int i = 0; i < 600; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (lfsr[11:10] == 2'b00) idle();
      else doRef({7'h0, lfsr[8:0]});
    end
    idle();
    repeat (3) @(negedge clk);
    check("R8 all responses seen", {32'h0, 32'(q.size())}, 64'h0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule